// File: doc/BRIEF.md
# External Memory Bus Strobe and Address Multiplexer

This block drives the strobes and the shared address/data pins of a byte-wide external memory bus for a microcontroller whose machine cycle lasts twelve oscillator periods. An outside phase counter tells the block where it is inside the machine cycle. From that phase the block generates the address latch strobe, the active-low program read strobe and the active-low data read and write strobes. It also multiplexes the low address byte and the write data onto one byte-wide port, and it chooses the value of the high address port.

When nothing but instruction fetch takes place, each half machine cycle carries one address latch pulse and one program read pulse. The core can request an external data access. The block samples that request on the clock edge that ends phase 5. The access window then runs from phase 6 of the same machine cycle to phase 5 of the next one. Inside the window the block puts the data address out with the second latch pulse of the first cycle. It drops both program read pulses and the first latch pulse of the following cycle, and drives the data read or write strobe. The data address is either a full 16-bit pointer or an 8-bit address. With the 8-bit form, the high port shows the port register contents.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While `rst` is high: `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `p0_oe`=0, `p0_out`=8'hFF and `p2_out`=8'hFF. Reset clears any pending access.
- R2: Outside an access window, `ale` is high in phases 0, 1, 6 and 7, and `psen_n` is low in phases 3–5 and 9–11. This gives two pulses of each per machine cycle.
- R3: Outside an access window, `p0_out` drives `pc[7:0]` with `p0_oe`=1 in phases 0–2 and 6–8. Port 0 is released (`p0_oe`=0, `p0_out`=8'hFF) in phases 3–5 and 9–11. `p2_out` equals `pc[15:8]`.
- R4: `xreq` is sampled only at the clock edge that ends phase 5 while no window is open. It is ignored at every other phase and during an open window. When `xreq` is held high, windows therefore start every second machine cycle.
- R5: In a window, the latch pulse in phases 6–7 is kept. The latch pulse in phases 0–1 of the next cycle is omitted, and `psen_n` stays high for the whole window. Over the two machine cycles this gives 3 latch pulses and 2 program read pulses.
- R6: In phases 6–8 of a window, port 0 drives the low byte of the access address. The address is `dptr` if `xwide`=1, else `addr8`, taken at the request edge.
- R7: On a read window (`xwrite`=0 at request), `rd_n` is low in phases 9–11 and 0–3, and port 0 is released from phase 9 through phase 5.
- R8: On a write window (`xwrite`=1 at request), `wr_n` is low in phases 9–11 and 0–3. Port 0 drives the `wdata` captured at the request in phases 9–11 and 0–4, which is one period past the rising edge of `wr_n`, and is released in phase 5.
- R9: During a window, `p2_out` is `dptr[15:8]` captured at the request if `xwide`=1, else the live `p2_reg` value.
- R10: `rd_n` and `wr_n` are never low together, and both stay high outside a window.
- R11: Phase values 12–15 produce no strobe: `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, port 0 released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 4 | Oscillator period within the machine cycle, 0–11 |
| xreq | input | 1 | External data access request |
| xwrite | input | 1 | 1 = write access, 0 = read access |
| xwide | input | 1 | 1 = 16-bit pointer address, 0 = 8-bit address |
| pc | input | 16 | Program counter for fetch addresses |
| dptr | input | 16 | 16-bit data pointer |
| addr8 | input | 8 | 8-bit data address |
| p2_reg | input | 8 | Port 2 register contents |
| wdata | input | 8 | Write data |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Port 0 address/data value |
| p0_oe | output | 1 | Port 0 drive enable |
| p2_out | output | 8 | Port 2 value |

## Verification
The assertions check on every cycle the relations between strobes that must hold in any phase. They cover the reset state, latch against program read, read against write, port 0 driving under each latch pulse and under the write strobe, write data held one period after the write strobe rises, a quiet program strobe during data strobes, and silence on illegal phases. Only the bench scenarios can show the exact phase placement of each pulse and the pulse counts over a window. They also show that a request is sampled at a single edge, that captured addresses and data are chosen correctly, and the choice between pointer byte and port register on port 2.

// File: rtl/xbus_strobe_gen.sv
`timescale 1ns/1ps
module xbus_strobe_gen #(
  parameter int DW  = 8,
  parameter int CYC = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [$clog2(CYC)-1:0] phase,
  input  logic                  xreq,
  input  logic                  xwrite,
  input  logic                  xwide,
  input  logic [2*DW-1:0]       pc,
  input  logic [2*DW-1:0]       dptr,
  input  logic [DW-1:0]         addr8,
  input  logic [DW-1:0]         p2_reg,
  input  logic [DW-1:0]         wdata,
  output logic                  ale,
  output logic                  psen_n,
  output logic                  rd_n,
  output logic                  wr_n,
  output logic [DW-1:0]         p0_out,
  output logic                  p0_oe,
  output logic [DW-1:0]         p2_out
);
  localparam int AW = 2 * DW;
  localparam int PW = $clog2(CYC);
  localparam logic [PW-1:0] HALF    = PW'(CYC / 2);
  localparam logic [PW-1:0] LAST    = PW'(CYC / 2 - 1);
  localparam logic [PW-1:0] LIMIT   = PW'(CYC);
  localparam logic [PW-1:0] S_LATCH = PW'(2);
  localparam logic [PW-1:0] S_ADDR  = PW'(3);
  localparam logic [PW-1:0] S_STRB  = PW'(3);
  localparam logic [PW-1:0] S_HOLD  = PW'(4);

  logic          xact;
  logic          x_wr;
  logic          x_wide;
  logic [AW-1:0] x_addr;
  logic [DW-1:0] x_wdat;

  always_ff @(posedge clk) begin
    if (rst) begin
      xact   <= 1'b0;
      x_wr   <= 1'b0;
      x_wide <= 1'b0;
      x_addr <= '0;
      x_wdat <= '0;
    end else if (phase == LAST) begin
      if (xact) begin
        xact <= 1'b0;
      end else if (xreq) begin
        xact   <= 1'b1;
        x_wr   <= xwrite;
        x_wide <= xwide;
        x_addr <= xwide ? dptr : {{DW{1'b0}}, addr8};
        x_wdat <= wdata;
      end
    end
  end

  logic          valid, upper, lead, tail;
  logic [PW-1:0] sub;
  logic          strobe, addr_ph, wdat_ph;

  assign valid = !rst && (phase < LIMIT);
  assign upper = phase >= HALF;
  assign sub   = upper ? phase - HALF : phase;
  assign lead  = xact && upper;
  assign tail  = xact && !upper;

  assign strobe  = valid && ((lead && sub >= S_STRB) || (tail && sub <= S_STRB));
  assign addr_ph = valid && (sub < S_ADDR) && !tail;
  assign wdat_ph = valid && x_wr && ((lead && sub >= S_STRB) || (tail && sub <= S_HOLD));

  assign ale    = valid && (sub < S_LATCH) && !tail;
  assign psen_n = !(valid && (sub >= S_STRB) && !xact);
  assign rd_n   = !(strobe && !x_wr);
  assign wr_n   = !(strobe && x_wr);
  assign p0_oe  = addr_ph || wdat_ph;

  assign p0_out = addr_ph ? (lead ? x_addr[DW-1:0] : pc[DW-1:0]) :
                  wdat_ph ? x_wdat : {DW{1'b1}};

  assign p2_out = rst    ? {DW{1'b1}} :
                  !xact  ? pc[AW-1:DW] :
                  x_wide ? x_addr[AW-1:DW] : p2_reg;
endmodule

// File: rtl/xbus_strobe_chk.sv
`timescale 1ns/1ps
module xbus_strobe_chk #(
  parameter int DW  = 8,
  parameter int CYC = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic [$clog2(CYC)-1:0] phase,
  input logic                   ale,
  input logic                   psen_n,
  input logic                   rd_n,
  input logic                   wr_n,
  input logic [DW-1:0]          p0_out,
  input logic                   p0_oe
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |-> (!ale && psen_n && rd_n && wr_n && !p0_oe));

  // R2
  ale_psen_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ale && !psen_n));

  // R2
  ale_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ale) && phase != 0 && phase != (CYC/2)) |-> 1'b0);

  // R10
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R3
  ale_drives_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> p0_oe);

  // R8
  wr_data_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> p0_oe);

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> (p0_oe && $stable(p0_out)));

  // R5
  psen_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> psen_n);

  // R11
  bad_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (phase >= CYC) |-> (!ale && psen_n && rd_n && wr_n && !p0_oe));
endmodule

bind xbus_strobe_gen xbus_strobe_chk #(.DW(DW), .CYC(CYC)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .ale(ale), .psen_n(psen_n),
  .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe)
);

// File: tb/test_xbus_strobe_gen.sv
`timescale 1ns/1ps
module test_xbus_strobe_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  phase = '0;
  logic        xreq = 1'b0, xwrite = 1'b0, xwide = 1'b0;
  logic [15:0] pc = '0, dptr = '0;
  logic [7:0]  addr8 = '0, p2_reg = '0, wdata = '0;
  logic        ale, psen_n, rd_n, wr_n, p0_oe;
  logic [7:0]  p0_out, p2_out;

  always #5 clk = ~clk;

  xbus_strobe_gen i_xbus_strobe_gen (
    .clk(clk), .rst(rst), .phase(phase), .xreq(xreq), .xwrite(xwrite),
    .xwide(xwide), .pc(pc), .dptr(dptr), .addr8(addr8), .p2_reg(p2_reg),
    .wdata(wdata), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out)
  );

  int vectors = 0, errors = 0;
  logic        m_act = 0, m_wr = 0, m_wide = 0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_wd = '0;
  int          ale_cnt, psen_cnt;
  logic        prev_ale, prev_psen;

  task automatic chk(string tag, string nm, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h phase=%0d", tag, nm, act, exp, phase);
    end
  endtask

  function automatic bit in_list(int ph, int a, int b, int c, int d);
    return ph == a || ph == b || ph == c || ph == d;
  endfunction

  task automatic step(int ph, bit req);
    bit lead, tail, e_ale, e_psen_n, e_rd_n, e_wr_n, e_oe, strb;
    logic [7:0] e_p0, e_p2;
    string t_str, t_p0;
    @(negedge clk);
    phase  = 4'(ph);
    xreq   = req;
    xwrite = 1'($urandom);
    xwide  = 1'($urandom);
    pc     = 16'($urandom);
    dptr   = 16'($urandom);
    addr8  = 8'($urandom);
    p2_reg = 8'($urandom);
    wdata  = 8'($urandom);
    #1;
    lead = m_act && ph >= 6 && ph < 12;
    tail = m_act && ph < 6;
    e_ale = 0; e_psen_n = 1; e_rd_n = 1; e_wr_n = 1; e_oe = 0; e_p0 = 8'hFF;
    if (rst) begin
      e_p2 = 8'hFF; t_str = "R1"; t_p0 = "R1";
    end else begin
      e_p2 = !m_act ? pc[15:8] : (m_wide ? m_addr[15:8] : p2_reg);
      t_str = ph > 11 ? "R11" : (m_act ? "R5" : "R2");
      t_p0  = ph > 11 ? "R11" : lead && ph <= 8 ? "R6" : m_act ? (m_wr ? "R8" : "R7") : "R3";
      if (ph <= 11) begin
        e_ale    = in_list(ph, 0, 1, 6, 7) && !tail;
        e_psen_n = !(!m_act && (in_list(ph, 3, 4, 5, 9) || ph == 10 || ph == 11));
        strb     = (lead && ph >= 9) || (tail && ph <= 3);
        e_rd_n   = !(strb && !m_wr);
        e_wr_n   = !(strb && m_wr);
        if ((ph <= 2 || (ph >= 6 && ph <= 8)) && !tail) begin
          e_oe = 1; e_p0 = lead ? m_addr[7:0] : pc[7:0];
        end else if (m_wr && ((lead && ph >= 9) || (tail && ph <= 4))) begin
          e_oe = 1; e_p0 = m_wd;
        end
      end
    end
    chk(t_str, "ale", 16'(ale), 16'(e_ale));
    chk(t_str, "psen_n", 16'(psen_n), 16'(e_psen_n));
    chk(m_act ? "R7" : "R10", "rd_n", 16'(rd_n), 16'(e_rd_n));
    chk(m_act ? "R8" : "R10", "wr_n", 16'(wr_n), 16'(e_wr_n));
    chk(t_p0, "p0_oe", 16'(p0_oe), 16'(e_oe));
    chk(t_p0, "p0_out", 16'(p0_out), 16'(e_p0));
    chk(rst ? "R1" : (m_act ? "R9" : "R3"), "p2_out", 16'(p2_out), 16'(e_p2));
    if (ale && !prev_ale) ale_cnt++;
    if (!psen_n && prev_psen) psen_cnt++;
    prev_ale = ale; prev_psen = psen_n;
    if (rst) m_act = 0;
    else if (ph == 5) begin
      if (m_act) m_act = 0;
      else if (req) begin
        m_act = 1; m_wr = xwrite; m_wide = xwide;
        m_addr = xwide ? dptr : {8'h00, addr8}; m_wd = wdata;
      end
    end
  endtask

  task automatic cycle(int mode);
    for (int p = 0; p < 12; p++)
      step(p, mode == 2 ? 1'b1 : mode == 1 ? (p == 5) : mode == 3 ? ($urandom_range(0, 9) < 3) : 1'b0);
  endtask

  task automatic clr_counts();
    ale_cnt = 0; psen_cnt = 0; prev_ale = 0; prev_psen = 0;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0051));
    clr_counts();
    rst = 1;
    // R1: reset state, including request pulses
    cycle(2);
    @(negedge clk); rst = 0;
    cycle(0);
    // R2: idle pulse counts
    clr_counts(); cycle(0); cycle(0);
    chk("R2", "ale pulses", 16'(ale_cnt), 16'd4);
    chk("R2", "psen pulses", 16'(psen_cnt), 16'd4);
    // R5: one access over two cycles
    clr_counts(); cycle(1); cycle(0);
    chk("R5", "ale pulses", 16'(ale_cnt), 16'd3);
    chk("R5", "psen pulses", 16'(psen_cnt), 16'd2);
    // R4: request held high
    clr_counts(); for (int c = 0; c < 4; c++) cycle(2);
    chk("R4", "ale pulses", 16'(ale_cnt), 16'd6);
    chk("R4", "psen pulses", 16'(psen_cnt), 16'd4);
    cycle(0); cycle(0);
    // R11: illegal phases, request ignored there
    for (int p = 12; p < 16; p++) step(p, 1'b1);
    cycle(0);
    // R1: reset in the middle of a window
    cycle(1);
    for (int p = 0; p < 3; p++) step(p, 1'b0);
    @(negedge clk); rst = 1;
    cycle(0);
    @(negedge clk); rst = 0;
    // R6 R7 R8 R9: random traffic
    for (int c = 0; c < 1500; c++) cycle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule